// File: doc/BRIEF.md
# Multiplexed External Peripheral Bus Master

This block turns single internal requests into cycles on a narrow external peripheral bus. The bus has an 8-bit bidirectional data path, and the upper address bits share that path in time. A requester presents a 28-bit address, a read/write flag, a 2-bit device index and a write byte. The block then runs one address phase per external latch. Each phase drives one address byte onto the data lines and pulses that latch's strobe. After the address phases it runs a single data phase with one chip select active.

The data phase lasts at least a configured number of wait clocks. After that it keeps going until the addressed device signals ready. The control pins follow one of two styles, chosen by a static configuration input. In the first style there are separate active-low read and write strobes. In the second there is an active-high enable plus a read/write level. A read returns the sampled byte with a one-clock done pulse. An external interrupt line is forwarded unchanged to the serial interrupt logic outside the block.

Top module: `xbus_master`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the outputs inactive: busy and done low, strobe 0, cs_n all ones, xd_oe low, addr_out 0, ctl_b high. ctl_a is high in the separate-strobe style (enable_style=0) and low in the enable style (enable_style=1).
- R2: A request is taken on a clock edge where req_valid is high and busy is low. busy then stays high until the transaction ends. A req_valid seen while busy is high is ignored: no second transaction follows the done pulse.
- R3: There is one address phase per latch (LATCHES=3 by default), in the order k=0,1,2. Each phase is three clocks long: a setup clock, a clock with strobe bit k high, and a hold clock. During all three clocks xd_oe is high and xd_out carries A[8k+11:8k+4]. Only one strobe bit is ever high.
- R4: addr_out carries A[11:0] of the accepted request from the clock after acceptance onward.
- R5: During the data phase exactly one chip select is low: cs_n[i] for the request index i. All chip selects are high at every other time.
- R6: Separate-strobe style (enable_style=0): ctl_a is low only during a read data phase and ctl_b is low only during a write data phase. Both are high otherwise.
- R7: Enable style (enable_style=1): ctl_a is high only during the data phase. ctl_b is low during a write data phase and high at all other times.
- R8: The data phase lasts at least min_wait+1 clocks. min_wait is captured when the request is taken.
- R9: Once the minimum is met, the data phase ends on the first clock edge at which ready is high. While ready is low it continues.
- R10: During a read data phase xd_oe is low. rdata takes xd_in from the edge that ends the phase. done is high for exactly the one following clock, with busy already low.
- R11: During a write data phase xd_out carries the write byte with xd_oe high. This drive continues for one hold clock after the phase, with the chip selects and controls inactive. done pulses for one clock after that hold clock.
- R12: irq_out follows irq_in with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable_style | input | 1 | 0: separate read/write strobes, 1: enable plus read/write level; hold stable while busy |
| min_wait | input | WAIT_W | Minimum extra data-phase clocks |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 28 | Request address |
| req_cs | input | 2 | Device index |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Last read byte |
| addr_out | output | 12 | Dedicated low address pins |
| xd_out | output | 8 | Data/address bus output value |
| xd_oe | output | 1 | Data bus output enable |
| xd_in | input | 8 | Data bus input value |
| strobe | output | 3 | Address latch strobes, active high |
| cs_n | output | 4 | Chip selects, active low |
| ctl_a | output | 1 | Read strobe (low) or enable (high) |
| ctl_b | output | 1 | Write strobe (low) or read/write level |
| ready | input | 1 | Device ready; low extends the data phase |
| irq_in | input | 1 | External interrupt |
| irq_out | output | 1 | Forwarded interrupt |

## Verification
The bench sweeps the wait setting against ready delays that fall below, at and above it. A design that counted wait clocks wrongly, or ignored ready, would end the data phase a clock early or late, and the chip-select checks would catch this. Read data is put on xd_in only during the final data clock. A design that sampled one edge early or late would therefore return a garbage byte. Write cycles check the extra hold clock. Requests left asserted during a busy cycle check that no phantom transaction starts after done. Both control styles are checked clock by clock against the idle and active levels.

// File: rtl/xbus_master.sv
module xbus_master #(
  parameter int LATCHES = 3,
  parameter int WAIT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_style,
  input  logic [WAIT_W-1:0] min_wait,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [27:0]       req_addr,
  input  logic [1:0]        req_cs,
  input  logic [7:0]        req_wdata,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rdata,
  output logic [11:0]       addr_out,
  output logic [7:0]        xd_out,
  output logic              xd_oe,
  input  logic [7:0]        xd_in,
  output logic [2:0]        strobe,
  output logic [3:0]        cs_n,
  output logic              ctl_a,
  output logic              ctl_b,
  input  logic              ready,
  input  logic              irq_in,
  output logic              irq_out
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STB, S_HOLD, S_DATA, S_WHOLD} state_t;

  localparam logic [1:0] LAST_K = 2'(LATCHES - 1);

  state_t            state;
  logic [1:0]        k;
  logic [WAIT_W-1:0] cnt;
  logic [27:0]       addr_q;
  logic              wr_q;
  logic [1:0]        cs_q;
  logic [7:0]        wdata_q;

  wire addr_phase = (state == S_SETUP) || (state == S_STB) || (state == S_HOLD);
  wire data_phase = (state == S_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      k       <= '0;
      cnt     <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      cs_q    <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wr_q    <= req_write;
          cs_q    <= req_cs;
          wdata_q <= req_wdata;
          cnt     <= min_wait;
          k       <= '0;
          state   <= S_SETUP;
        end
        S_SETUP: state <= S_STB;
        S_STB:   state <= S_HOLD;
        S_HOLD: begin
          if (k == LAST_K) state <= S_DATA;
          else begin
            k     <= k + 2'd1;
            state <= S_SETUP;
          end
        end
        S_DATA: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (ready) begin
            if (wr_q) state <= S_WHOLD;
            else begin
              rdata <= xd_in;
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end
        end
        S_WHOLD: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy     = (state != S_IDLE);
  assign addr_out = addr_q[11:0];
  assign xd_oe    = addr_phase || (wr_q && (data_phase || state == S_WHOLD));
  assign xd_out   = addr_phase ? addr_q[8*int'(k)+4 +: 8] : (xd_oe ? wdata_q : 8'h00);
  assign strobe   = (state == S_STB) ? 3'(1 << k) : 3'b000;
  assign cs_n     = data_phase ? ~4'(1 << cs_q) : 4'hF;
  assign ctl_a    = enable_style ? data_phase : ~(data_phase && !wr_q);
  assign ctl_b    = enable_style ? ~(data_phase && wr_q) : ~(data_phase && wr_q);
  assign irq_out  = irq_in;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ((&cs_n) && strobe == 3'b000 && !xd_oe));

  assert_strobe_setup_R3: assert property (@(posedge clk) disable iff (rst)
    (|strobe) |-> (xd_oe && $past(xd_oe) && xd_out == $past(xd_out) && $past(strobe) == 3'b000));

  assert_strobe_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (|$past(strobe)) |-> (xd_oe && xd_out == $past(xd_out) && strobe == 3'b000));

  assert_ready_extends_R9: assert property (@(posedge clk) disable iff (rst)
    (!(&cs_n) && !ready) |=> !(&cs_n));

  assert_done_after_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(busy) && !busy));

endmodule

// File: tb/xbus_master_bench.sv
module xbus_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LATCHES = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable_style = 1'b0;
  logic [2:0] min_wait = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [27:0] req_addr = '0;
  logic [1:0] req_cs = '0;
  logic [7:0] req_wdata = '0, xd_in = '0;
  logic ready = 1'b0, irq_in = 1'b0;
  logic busy, done, xd_oe, ctl_a, ctl_b, irq_out;
  logic [7:0] rdata, xd_out;
  logic [11:0] addr_out;
  logic [2:0] strobe;
  logic [3:0] cs_n;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_master #(.LATCHES(LATCHES), .WAIT_W(3)) u_xbus_master (
    .clk(clk), .rst(rst), .enable_style(enable_style), .min_wait(min_wait),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_cs(req_cs), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rdata(rdata), .addr_out(addr_out), .xd_out(xd_out), .xd_oe(xd_oe),
    .xd_in(xd_in), .strobe(strobe), .cs_n(cs_n), .ctl_a(ctl_a), .ctl_b(ctl_b),
    .ready(ready), .irq_in(irq_in), .irq_out(irq_out));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_a(input logic sty, input logic act, input logic wr);
    return sty ? act : !(act && !wr);
  endfunction

  function automatic logic exp_b(input logic sty, input logic act, input logic wr);
    return !(act && wr);
  endfunction

  function automatic logic [7:0] addr_byte(input logic [27:0] a, input int k);
    return a[8*k+4 +: 8];
  endfunction

  task automatic idle_checks(input string tag);
    chk({tag, " busy"}, 32'(busy), 32'd0);
    chk({tag, " cs_n"}, 32'(cs_n), 32'hF);
    chk({tag, " strobe"}, 32'(strobe), 32'd0);
    chk({tag, " oe"}, 32'(xd_oe), 32'd0);
    chk({tag, " ctl_a"}, 32'(ctl_a), 32'(exp_a(enable_style, 1'b0, 1'b0)));
    chk({tag, " ctl_b"}, 32'(ctl_b), 32'(exp_b(enable_style, 1'b0, 1'b0)));
  endtask

  task automatic run_txn(input logic sty, input logic [2:0] w, input int d, input logic wr,
                         input logic [27:0] a, input logic [1:0] cs, input logic [7:0] wd,
                         input logic [7:0] rd, input logic spam);
    int last;
    enable_style = sty; min_wait = w; req_write = wr; req_addr = a;
    req_cs = cs; req_wdata = wd; req_valid = 1'b1; ready = 1'b0;
    @(posedge clk); @(negedge clk);
    req_valid = spam;
    req_addr = ~a; req_write = ~wr; min_wait = ~w;
    for (int k = 0; k < LATCHES; k++) begin
      chk("R2 busy", 32'(busy), 32'd1);
      chk("R4 addr_out", 32'(addr_out), 32'(a[11:0]));
      chk("R3 setup byte", 32'(xd_out), 32'(addr_byte(a, k)));
      chk("R3 setup oe", 32'(xd_oe), 32'd1);
      chk("R3 setup strobe", 32'(strobe), 32'd0);
      chk("R5 cs idle in address", 32'(cs_n), 32'hF);
      @(negedge clk);
      chk("R3 strobe", 32'(strobe), 32'(1 << k));
      chk("R3 strobe byte", 32'(xd_out), 32'(addr_byte(a, k)));
      @(negedge clk);
      chk("R3 hold strobe", 32'(strobe), 32'd0);
      chk("R3 hold byte", 32'(xd_out), 32'(addr_byte(a, k)));
      chk("R3 hold oe", 32'(xd_oe), 32'd1);
      @(negedge clk);
    end
    last = (int'(w) > d) ? int'(w) : d;
    for (int i = 0; i <= last; i++) begin
      ready = (i >= d);
      xd_in = (i == last) ? rd : ~rd;
      chk("R5 cs data", 32'(cs_n), 32'(~(4'b1 << cs) & 4'hF));
      chk(sty ? "R7 ctl_a" : "R6 ctl_a", 32'(ctl_a), 32'(exp_a(sty, 1'b1, wr)));
      chk(sty ? "R7 ctl_b" : "R6 ctl_b", 32'(ctl_b), 32'(exp_b(sty, 1'b1, wr)));
      if (wr) begin
        chk("R11 write oe", 32'(xd_oe), 32'd1);
        chk("R11 write byte", 32'(xd_out), 32'(wd));
      end else chk("R10 read released", 32'(xd_oe), 32'd0);
      if (i < w) chk("R8 min wait", 32'(done), 32'd0);
      else if (i < d) chk("R9 ready low holds", 32'(busy), 32'd1);
      @(negedge clk);
    end
    ready = 1'b0; xd_in = 8'h5A;
    if (wr) begin
      chk("R11 hold oe", 32'(xd_oe), 32'd1);
      chk("R11 hold byte", 32'(xd_out), 32'(wd));
      chk("R11 hold cs", 32'(cs_n), 32'hF);
      chk("R11 hold ctl_a", 32'(ctl_a), 32'(exp_a(sty, 1'b0, wr)));
      chk("R11 hold ctl_b", 32'(ctl_b), 32'(exp_b(sty, 1'b0, wr)));
      chk("R11 no early done", 32'(done), 32'd0);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R11 done", 32'(done), 32'd1);
    end else begin
      req_valid = 1'b0;
      chk("R10 done", 32'(done), 32'd1);
      chk("R10 rdata", 32'(rdata), 32'(rd));
    end
    idle_checks("R10 end");
    @(negedge clk);
    chk("R10 single done", 32'(done), 32'd0);
    chk("R2 no phantom", 32'(busy), 32'd0);
    chk("R2 no phantom strobe", 32'(strobe), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle_checks("R1 reset");
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 addr_out", 32'(addr_out), 32'd0);
    enable_style = 1'b1; #1;
    chk("R1 enable idle ctl_a", 32'(ctl_a), 32'd0);
    chk("R1 enable idle ctl_b", 32'(ctl_b), 32'd1);
    enable_style = 1'b0;
    irq_in = 1'b1; #1; chk("R12 irq high", 32'(irq_out), 32'd1);
    irq_in = 1'b0; #1; chk("R12 irq low", 32'(irq_out), 32'd0);
    @(negedge clk);
    run_txn(1'b0, 3'd0, 0, 1'b0, 28'hABCDEF1, 2'd0, 8'h00, 8'hC3, 1'b0);
    run_txn(1'b1, 3'd0, 0, 1'b1, 28'h1234567, 2'd3, 8'hA5, 8'h00, 1'b0);
    run_txn(1'b0, 3'd7, 0, 1'b1, 28'hFFFFFFF, 2'd1, 8'h3C, 8'h00, 1'b1);
    run_txn(1'b1, 3'd2, 9, 1'b0, 28'h0000010, 2'd2, 8'h00, 8'h7E, 1'b1);
    run_txn(1'b0, 3'd3, 3, 1'b0, 28'h8421084, 2'd1, 8'h00, 8'h99, 1'b0);
    for (int n = 0; n < 40; n++) begin
      run_txn(1'($urandom), 3'($urandom), int'($urandom % 11), 1'($urandom),
              28'($urandom), 2'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    end
    rst = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; req_valid = 1'b0;
    idle_checks("R1 reset again");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule